// File: doc/BRIEF.md
# CPU Clock Stop Gate

This block passes a free-running internal CPU clock to a small group of true and complement outputs and halts that group when an asynchronous, active-low stop pin is driven. Other clock domains are not routed through it. The pin is first brought into the CPU clock domain by a two-stage synchronizer. A three-state controller then decides whether the gate is open. A gate register clocked on the falling edge applies that decision, so the outputs always park low and always restart with a complete high phase.

The controller has three states. `GS_STOPPED` keeps the gate closed. `GS_WARMUP` holds the gate open while a saturating counter counts the minimum run interval. `GS_RUNNING` holds the gate open and obeys stop requests. Transitions:
- **STOPPED→WARMUP** happens when the synchronized pin reads high. The counter is cleared on that edge.
- **WARMUP→RUNNING** happens on the edge where the counter has reached `MIN_RUN-1`. Stop requests are not looked at during WARMUP.
- **RUNNING→STOPPED** happens when the synchronized pin reads low.
- Reset enters STOPPED.

Each output also has a separate enable input, intended to be tied to a control register bit. Clearing it forces that output low, with its complement high, while the other outputs keep running.

Top module: `cpu_clk_stop_gate`

## Requirements
- R1: While reset is asserted, every true output is low, every complement output is high and `stopped_o` is high.
- R2: With a 10 ns clock, when `stop_ni` rises 1 ns after a rising clock edge while the gate is closed, the first rising edge on a true output comes on the fourth following clock edge, 39 ns after the pin change. This is less than 4 clock cycles. Release of reset with `stop_ni` high behaves the same way.
- R3: When `stop_ni` falls 1 ns after a rising edge in state RUNNING, the last high pulse on a true output starts on the third following clock edge, 29 ns after the pin change. The output is low and halted 34 ns after the pin change.
- R4: While the gate is closed, `stopped_o` is high, all true outputs stay low with no pulses, and all complement outputs stay high.
- R5: Every high pulse of a true output lasts the full high phase of `clk_i`, and a true output is never high while `clk_i` is low.
- R6: Once the gate opens, it stays open for at least `MIN_RUN` clock pulses (default 100). When a stop request is already pending from the start of the interval, exactly `MIN_RUN+1` pulses are issued, and then the gate closes.
- R7: A stop request that is asserted and withdrawn entirely within the WARMUP interval has no effect. `stopped_o` stays low and no pulse is lost.
- R8: Clearing `out_en_i[i]` holds true output i low and complement output i high, and the other outputs and `stopped_o` are unaffected. Setting the bit again restores full pulses on output i.
- R9: Each complement output is always the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running internal CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_ni | input | 1 | Asynchronous active-low stop request pin |
| out_en_i | input | NUM_OUT | Per-output enable (1 = output may run) |
| clk_t_o | output | NUM_OUT | Gated true clock outputs |
| clk_c_o | output | NUM_OUT | Gated complement clock outputs |
| stopped_o | output | 1 | High whenever the gate is closed |

## Verification
The pin is changed 1 ns after a rising edge. This makes the exact times of the first and last pulses checkable to the nanosecond, and it separates a missing or extra synchronizer stage from a correct one. A stop request that is pending from the moment the gate opens is used to count the minimum interval pulse by pulse, which shows an off-by-one in the run counter. A request that is withdrawn during WARMUP shows whether the controller wrongly samples the pin in that state. Toggling a single output enable while the others run shows whether the enables are isolated from each other and from the status flag. A pulse-width monitor watches every high phase for shortened pulses.

// File: rtl/cpu_gate_pkg.sv
`timescale 1ns/1ps
package cpu_gate_pkg;

    typedef enum logic [1:0] {
        GS_STOPPED = 2'd0,
        GS_WARMUP  = 2'd1,
        GS_RUNNING = 2'd2
    } gate_state_e;

endpackage

// File: rtl/cpu_gate_sync.sv
`timescale 1ns/1ps
module cpu_gate_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cpu_gate_run_fsm.sv
`timescale 1ns/1ps
module cpu_gate_run_fsm
    import cpu_gate_pkg::*;
#(
    parameter int MIN_RUN = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    output logic run_o
);

    localparam int CNT_W = $clog2(MIN_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(MIN_RUN - 1);
    localparam logic [CNT_W-1:0] HOLD_DONE = CNT_W'(MIN_RUN);

    gate_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_STOPPED: if (go_i)                 state_d = GS_WARMUP;
            GS_WARMUP:  if (cnt_q == HOLD_LAST)   state_d = GS_RUNNING;
            GS_RUNNING: if (!go_i)                state_d = GS_STOPPED;
            default:                              state_d = GS_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= GS_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // saturating run-interval counter, held at zero while closed
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (state_q == GS_STOPPED) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        run_o = (state_q != GS_STOPPED);
    end

    // R6
    min_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == GS_RUNNING && state_d == GS_STOPPED) |-> (cnt_q >= HOLD_DONE));

    // R6
    no_skip_warmup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == GS_STOPPED) |=> (state_q != GS_RUNNING));

endmodule

// File: rtl/cpu_gate_drive.sv
`timescale 1ns/1ps
module cpu_gate_drive #(
    parameter int NUM_OUT = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic [NUM_OUT-1:0] out_en_i,
    output logic [NUM_OUT-1:0] clk_t_o,
    output logic [NUM_OUT-1:0] clk_c_o,
    output logic               stopped_o
);

    logic open_q;

    // group gate, updated only while the clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            open_q <= 1'b0;
        end else begin
            open_q <= run_i;
        end
    end

    assign stopped_o = ~open_q;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        logic lane_q;

        always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                lane_q <= 1'b0;
            end else begin
                lane_q <= run_i & out_en_i[g];
            end
        end

        assign clk_t_o[g] = clk_i & lane_q;
        assign clk_c_o[g] = ~(clk_i & lane_q);
    end

    // R5
    low_phase_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_t_o == '0) && (clk_c_o == '1));

    // R4
    closed_quiet_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        stopped_o |-> (clk_t_o == '0));

endmodule

// File: rtl/cpu_clk_stop_gate.sv
`timescale 1ns/1ps
module cpu_clk_stop_gate #(
    parameter int NUM_OUT     = 2,
    parameter int MIN_RUN     = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               stop_ni,
    input  logic [NUM_OUT-1:0] out_en_i,
    output logic [NUM_OUT-1:0] clk_t_o,
    output logic [NUM_OUT-1:0] clk_c_o,
    output logic               stopped_o
);

    logic go_sync;
    logic run;

    cpu_gate_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b0)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (stop_ni),
        .sync_o  (go_sync)
    );

    cpu_gate_run_fsm #(
        .MIN_RUN (MIN_RUN)
    ) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (go_sync),
        .run_o  (run)
    );

    cpu_gate_drive #(
        .NUM_OUT (NUM_OUT)
    ) u_drive (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .out_en_i  (out_en_i),
        .clk_t_o   (clk_t_o),
        .clk_c_o   (clk_c_o),
        .stopped_o (stopped_o)
    );

endmodule

// File: tb/cpu_clk_stop_gate_test.sv
`timescale 1ns/1ps
module cpu_clk_stop_gate_test;

    localparam int NOUT = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stop_n = 1'b1;
    logic [NOUT-1:0] out_en = '1;
    logic [NOUT-1:0] clk_t;
    logic [NOUT-1:0] clk_c;
    logic            stopped;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    int  rise_cnt0 = 0, rise_cnt1 = 0, short_cnt = 0;
    time first_rise0 = 0, last_rise0 = 0, last_fall0 = 0, last_rise1 = 0;
    time t0;

    always #5 clk = ~clk;

    cpu_clk_stop_gate #(.NUM_OUT(NOUT), .MIN_RUN(100), .SYNC_STAGES(2)) uut (
        .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .out_en_i(out_en),
        .clk_t_o(clk_t), .clk_c_o(clk_c), .stopped_o(stopped)
    );

    // pulse monitors
    always @(posedge clk_t[0]) begin
        rise_cnt0++;
        last_rise0 = $time;
        if (first_rise0 == 0) first_rise0 = $time;
    end
    always @(negedge clk_t[0]) begin
        last_fall0 = $time;
        if ($time - last_rise0 != 5) short_cnt++;
    end
    always @(posedge clk_t[1]) begin
        rise_cnt1++;
        last_rise1 = $time;
    end
    always @(negedge clk_t[1]) begin
        if ($time - last_rise1 != 5) short_cnt++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // sample during the high phase of clk
    task automatic high_phase();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        cycles(3);
        high_phase();
        check(clk_t == '0, "R1", "true outputs in reset", clk_t, 0);
        check(clk_c == '1, "R1", "complement outputs in reset", clk_c, 3);
        check(stopped == 1'b1, "R1", "stopped flag in reset", stopped, 1);
    endtask

    task automatic t_start();
        after_edge();
        first_rise0 = 0;
        rst_n = 1'b1;
        t0 = $time;
        cycles(10);
        check(first_rise0 - t0 == 39, "R2", "start latency after reset (ns)", first_rise0 - t0, 39);
        check(stopped == 1'b0, "R4", "stopped flag while open", stopped, 0);
    endtask

    task automatic t_stop();
        int snap;
        after_edge();
        stop_n = 1'b0;
        t0 = $time;
        cycles(10);
        check(last_rise0 - t0 == 29, "R3", "last pulse start (ns)", last_rise0 - t0, 29);
        check(last_fall0 - t0 == 34, "R3", "halt time (ns)", last_fall0 - t0, 34);
        snap = rise_cnt0;
        cycles(30);
        check(rise_cnt0 == snap, "R4", "pulses while stopped", rise_cnt0 - snap, 0);
        high_phase();
        check(stopped == 1'b1, "R4", "stopped flag while closed", stopped, 1);
        check(clk_t == '0, "R4", "true outputs parked low", clk_t, 0);
        check(clk_c == '1, "R9", "complement parked high", clk_c, 3);
    endtask

    task automatic t_restart();
        after_edge();
        first_rise0 = 0;
        stop_n = 1'b1;
        t0 = $time;
        cycles(10);
        check(first_rise0 - t0 == 39, "R2", "restart latency (ns)", first_rise0 - t0, 39);
        high_phase();
        check(clk_t == 2'b11, "R9", "true outputs high phase", clk_t, 3);
        check(clk_c == 2'b00, "R9", "complement outputs high phase", clk_c, 0);
    endtask

    task automatic t_withdraw();
        int highs = 0;
        int snap;
        cycles(20);
        snap = rise_cnt0;
        stop_n = 1'b0;
        for (int i = 0; i < 150; i++) begin
            if (i == 10) stop_n = 1'b1;
            high_phase();
            if (stopped) highs++;
        end
        check(highs == 0, "R7", "stopped cycles after withdrawn request", highs, 0);
        check(rise_cnt0 - snap == 150, "R7", "pulses across withdrawn request", rise_cnt0 - snap, 150);
    endtask

    task automatic t_enable();
        int s0, s1;
        after_edge();
        out_en = 2'b01;
        cycles(3);
        s0 = rise_cnt0;
        s1 = rise_cnt1;
        cycles(20);
        check(rise_cnt1 - s1 == 0, "R8", "disabled output pulses", rise_cnt1 - s1, 0);
        check(rise_cnt0 - s0 == 20, "R8", "other output pulses", rise_cnt0 - s0, 20);
        high_phase();
        check(clk_c[1] == 1'b1, "R8", "disabled complement level", clk_c[1], 1);
        check(stopped == 1'b0, "R8", "stopped flag with one output off", stopped, 0);
        after_edge();
        out_en = 2'b11;
        cycles(3);
        s1 = rise_cnt1;
        cycles(20);
        check(rise_cnt1 - s1 == 20, "R8", "re-enabled output pulses", rise_cnt1 - s1, 20);
    endtask

    task automatic t_minrun();
        int snap;
        after_edge();
        snap = rise_cnt0;
        stop_n = 1'b1;
        cycles(2);
        stop_n = 1'b0;
        cycles(150);
        check(rise_cnt0 - snap == 101, "R6", "pulses in minimum interval", rise_cnt0 - snap, 101);
        high_phase();
        check(stopped == 1'b1, "R6", "closed after minimum interval", stopped, 1);
    endtask

    initial begin
        t_reset();
        t_start();
        cycles(120);
        t_stop();
        t_restart();
        t_withdraw();
        t_enable();
        t_stop();
        t_minrun();
        check(short_cnt == 0, "R5", "shortened high pulses", short_cnt, 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule